// File: doc/BRIEF.md
# Retimed SPI Pass-Through Bridge

This block sits between an upstream SPI master and one or more downstream SPI slave boards. Everything runs on a single reference clock whose rising edges line up with the serial clock edges. Chip select, serial clock and master-out data toward each slave pass through one register, so they reach the slave exactly one reference cycle late. The slave's return data is registered once before it goes back upstream. While the forwarded chip select is inactive, the return line upstream is forced low. The bus runs in SPI mode 0: data changes on the falling serial clock edge and is captured on the rising edge.

The two retiming stages shorten the low phase of the serial clock, as the slave sees it, by two reference cycles. A slave that needs `N_PROC` cycles to present its data therefore needs each low phase to last at least `N_PROC + 2` reference cycles. A monitor state machine in each lane measures every low phase that starts with a falling serial clock edge inside a selected window. It raises a sticky error flag when a phase is too short.

The monitor has four states. `ST_IDLE` means chip select is inactive. `ST_ARMED` means the slave is selected but no rising edge has been seen yet. `ST_HIGH` means the serial clock is high. `ST_LOW` means the monitor is counting a low phase. Transitions:
- Any state goes to `ST_IDLE` whenever chip select is inactive.
- `ST_IDLE` goes to `ST_HIGH`, or to `ST_ARMED`, on selection, depending on the serial clock level.
- `ST_ARMED` goes to `ST_HIGH` on a high clock.
- `ST_HIGH` goes to `ST_LOW` on a low clock, which starts the count at one.
- `ST_LOW` goes to `ST_HIGH` on a high clock. This transition is where the length is judged.

The default build has two lanes, one for each slave board.

Top module: `spi_retime_bridge`

## Requirements
- R1: During and right after reset, every lane drives chip select high, serial clock low and master-out data low toward the slave, drives the upstream return line low, and holds the error flag low.
- R2: The downstream chip select, serial clock and master-out data each equal the value their upstream input had one reference cycle earlier.
- R3: While the forwarded chip select is low (active), the upstream return line equals the slave's return data from one reference cycle earlier.
- R4: While the forwarded chip select is high, the upstream return line is low, whatever the slave drives.
- R5: A serial clock low phase that starts with a falling edge while chip select is low does not set the error flag if it lasts N_PROC+2 or more reference cycles. N_PROC defaults to 2, so the minimum is 4.
- R6: When such a low phase lasts fewer than N_PROC+2 cycles, the error flag of that lane rises one cycle after the first high sample ends the phase. The flag then stays high until reset, including across chip select release.
- R7: The low stretch between chip select assertion and the first rising edge is not measured, and no clock activity while chip select is high sets the flag.
- R8: If chip select is released in the same cycle as the rising edge that ends a short low phase, the flag is not set.
- R9: Each lane measures and flags only its own bus; an error on one lane leaves the others' flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_cs_n | input | NUM_CH | Chip select from master, active low, one bit per lane |
| up_sclk | input | NUM_CH | Serial clock from master |
| up_mosi | input | NUM_CH | Master-out data from master |
| up_miso | output | NUM_CH | Registered, gated return data to master |
| dn_cs_n | output | NUM_CH | Retimed chip select to slave |
| dn_sclk | output | NUM_CH | Retimed serial clock to slave |
| dn_mosi | output | NUM_CH | Retimed master-out data to slave |
| dn_miso | input | NUM_CH | Return data from slave |
| div_err | output | NUM_CH | Sticky flag: low phase shorter than N_PROC+2 |

## Verification
Two functions can fall in the same cycle.

The first pair is the rising edge that ends a short low phase and the release of chip select, which would otherwise set the error flag. A directed case ends a two-cycle low phase with chip select going high on the very cycle the clock rises. The bench judges the flag against a run-length model that only counts a rise while chip select is low. The flag must stay low.

The second pair is the release of chip select and the return path. When the slave holds its return data high across deselection, the gate must win. Random bursts with random clock phase lengths and random chip select toggles hit both collisions repeatedly.

// File: rtl/spi_bridge_pkg.sv
package spi_bridge_pkg;

    // Low-phase monitor states
    typedef enum logic [1:0] {
        ST_IDLE,   // slave not selected
        ST_ARMED,  // selected, waiting for first rising edge
        ST_HIGH,   // serial clock high inside selection
        ST_LOW     // counting a low phase opened by a falling edge
    } mon_state_e;

    // Forward bundle toward the slave
    typedef struct packed {
        logic cs_n;
        logic sclk;
        logic mosi;
    } spi_fwd_t;

    localparam spi_fwd_t FWD_RESET = '{cs_n: 1'b1, sclk: 1'b0, mosi: 1'b0};

endpackage

// File: rtl/spi_fwd_retime.sv
module spi_fwd_retime
    import spi_bridge_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  spi_fwd_t up_i,
    output spi_fwd_t dn_o,
    input  logic     dn_miso_i,
    output logic     up_miso_o
);

    spi_fwd_t fwd_q;
    logic     ret_q;

    // forward stage toward slave
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_q <= FWD_RESET;
        end else begin
            fwd_q <= up_i;
        end
    end

    // return stage toward master
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_q <= 1'b0;
        end else begin
            ret_q <= dn_miso_i;
        end
    end

    always_comb begin
        dn_o      = fwd_q;
        up_miso_o = ret_q & ~fwd_q.cs_n;
    end

    // one cycle out of reset before $past is meaningful
    logic hist_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) hist_ok <= 1'b0;
        else        hist_ok <= 1'b1;
    end

    p_fwd_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hist_ok |-> (dn_o.sclk == $past(up_i.sclk)) && (dn_o.cs_n == $past(up_i.cs_n))
                    && (dn_o.mosi == $past(up_i.mosi)));

    p_ret_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && !dn_o.cs_n) |-> (up_miso_o == $past(dn_miso_i)));

    p_ret_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && $past(up_i.cs_n)) |-> !up_miso_o);

endmodule

// File: rtl/spi_div_checker.sv
module spi_div_checker
    import spi_bridge_pkg::*;
#(
    parameter int N_PROC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic sclk_i,
    output logic err_o
);

    localparam int MIN_LOW = N_PROC + 2;
    localparam int CW      = $clog2(MIN_LOW + 1);

    mon_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          err_q;
    logic          short_rise;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!cs_n_i) state_d = sclk_i ? ST_HIGH : ST_ARMED;
            end
            ST_ARMED: begin
                if (cs_n_i)      state_d = ST_IDLE;
                else if (sclk_i) state_d = ST_HIGH;
            end
            ST_HIGH: begin
                if (cs_n_i)       state_d = ST_IDLE;
                else if (!sclk_i) state_d = ST_LOW;
            end
            ST_LOW: begin
                if (cs_n_i)      state_d = ST_IDLE;
                else if (sclk_i) state_d = ST_HIGH;
            end
        endcase
    end

    assign short_rise = (state_q == ST_LOW) && !cs_n_i && sclk_i
                        && (cnt_q < CW'(MIN_LOW));

    // low-phase length counter and sticky flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            err_q <= 1'b0;
        end else begin
            if (state_q == ST_HIGH && !cs_n_i && !sclk_i) begin
                cnt_q <= CW'(1);
            end else if (state_q == ST_LOW && !cs_n_i && !sclk_i
                         && cnt_q != CW'(MIN_LOW)) begin
                cnt_q <= cnt_q + CW'(1);
            end
            if (short_rise) err_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        err_o = err_q;
    end

    p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    p_err_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> ($past(!cs_n_i) && $past(sclk_i)));

    p_release_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_i |=> (state_q == ST_IDLE));

    p_cs_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_i && state_q == ST_LOW) |=> $stable(err_o));

endmodule

// File: rtl/spi_bridge_lane.sv
module spi_bridge_lane
    import spi_bridge_pkg::*;
#(
    parameter int N_PROC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic up_cs_n,
    input  logic up_sclk,
    input  logic up_mosi,
    output logic up_miso,
    output logic dn_cs_n,
    output logic dn_sclk,
    output logic dn_mosi,
    input  logic dn_miso,
    output logic div_err
);

    spi_fwd_t up_bus, dn_bus;

    assign up_bus = '{cs_n: up_cs_n, sclk: up_sclk, mosi: up_mosi};
    assign dn_cs_n = dn_bus.cs_n;
    assign dn_sclk = dn_bus.sclk;
    assign dn_mosi = dn_bus.mosi;

    spi_fwd_retime u_retime (
        .clk       (clk),
        .rst_n     (rst_n),
        .up_i      (up_bus),
        .dn_o      (dn_bus),
        .dn_miso_i (dn_miso),
        .up_miso_o (up_miso)
    );

    spi_div_checker #(.N_PROC(N_PROC)) u_check (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n_i (up_cs_n),
        .sclk_i (up_sclk),
        .err_o  (div_err)
    );

endmodule

// File: rtl/spi_retime_bridge.sv
module spi_retime_bridge #(
    parameter int NUM_CH = 2,
    parameter int N_PROC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] up_cs_n,
    input  logic [NUM_CH-1:0] up_sclk,
    input  logic [NUM_CH-1:0] up_mosi,
    output logic [NUM_CH-1:0] up_miso,
    output logic [NUM_CH-1:0] dn_cs_n,
    output logic [NUM_CH-1:0] dn_sclk,
    output logic [NUM_CH-1:0] dn_mosi,
    input  logic [NUM_CH-1:0] dn_miso,
    output logic [NUM_CH-1:0] div_err
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
        spi_bridge_lane #(.N_PROC(N_PROC)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .up_cs_n (up_cs_n[g]),
            .up_sclk (up_sclk[g]),
            .up_mosi (up_mosi[g]),
            .up_miso (up_miso[g]),
            .dn_cs_n (dn_cs_n[g]),
            .dn_sclk (dn_sclk[g]),
            .dn_mosi (dn_mosi[g]),
            .dn_miso (dn_miso[g]),
            .div_err (div_err[g])
        );
    end

    p_lane_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_err[0]) |-> $past(!up_cs_n[0]));

endmodule

// File: tb/tb_spi_retime_bridge.sv
module tb_spi_retime_bridge;

    localparam int NUM_CH  = 2;
    localparam int N_PROC  = 2;
    localparam int MIN_LOW = N_PROC + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NUM_CH-1:0] d_cs = '1, d_sc = '0, d_mo = '0, d_mi = '0;
    logic [NUM_CH-1:0] up_miso, dn_cs_n, dn_sclk, dn_mosi, div_err;

    int checks = 0;
    int bad = 0;
    string err_tag = "R5";

    // reference model state
    logic [NUM_CH-1:0] m_err, m_valid, m_pcs, m_psc;
    int m_run [NUM_CH];
    logic in_reset = 1'b1;

    always #2 clk = ~clk;

    spi_retime_bridge #(.NUM_CH(NUM_CH), .N_PROC(N_PROC)) dut (
        .clk(clk), .rst_n(rst_n),
        .up_cs_n(d_cs), .up_sclk(d_sc), .up_mosi(d_mo), .up_miso(up_miso),
        .dn_cs_n(dn_cs_n), .dn_sclk(dn_sclk), .dn_mosi(dn_mosi),
        .dn_miso(d_mi), .div_err(div_err)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_err = '0; m_valid = '0; m_pcs = '1; m_psc = '0;
        for (int c = 0; c < NUM_CH; c++) m_run[c] = 0;
    endtask

    // run-length model of the low-phase rule
    task automatic model_update();
        for (int c = 0; c < NUM_CH; c++) begin
            if (d_cs[c]) begin
                m_valid[c] = 1'b0;
            end else if (!d_sc[c]) begin
                if (m_valid[c]) m_run[c]++;
                else if (!m_pcs[c] && m_psc[c]) begin
                    m_valid[c] = 1'b1;
                    m_run[c] = 1;
                end
            end else if (m_valid[c]) begin
                if (m_run[c] < MIN_LOW) m_err[c] = 1'b1;
                m_valid[c] = 1'b0;
            end
        end
        m_pcs = d_cs;
        m_psc = d_sc;
    endtask

    task automatic check_outputs();
        for (int c = 0; c < NUM_CH; c++) begin
            if (in_reset) begin
                chk("R1", "dn_cs_n", dn_cs_n[c], 1'b1);
                chk("R1", "dn_sclk", dn_sclk[c], 1'b0);
                chk("R1", "dn_mosi", dn_mosi[c], 1'b0);
                chk("R1", "up_miso", up_miso[c], 1'b0);
                chk("R1", "div_err", div_err[c], 1'b0);
            end else begin
                chk("R2", "dn_cs_n", dn_cs_n[c], d_cs[c]);
                chk("R2", "dn_sclk", dn_sclk[c], d_sc[c]);
                chk("R2", "dn_mosi", dn_mosi[c], d_mo[c]);
                if (d_cs[c]) chk("R4", "up_miso", up_miso[c], 1'b0);
                else         chk("R3", "up_miso", up_miso[c], d_mi[c]);
                chk(err_tag, "div_err", div_err[c], m_err[c]);
            end
        end
    endtask

    task automatic step();
        @(posedge clk);
        if (!in_reset) model_update();
        @(negedge clk);
        check_outputs();
    endtask

    task automatic drive(input logic [NUM_CH-1:0] c, input logic [NUM_CH-1:0] s, input int n);
        for (int k = 0; k < n; k++) begin
            d_cs = c; d_sc = s;
            d_mo = NUM_CH'($urandom);
            d_mi = NUM_CH'($urandom);
            step();
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; in_reset = 1'b1;
        d_cs = '1; d_sc = '0; d_mo = '0; d_mi = '1;
        model_reset();
        step();
        step();
        rst_n = 1'b1; in_reset = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        int rem [NUM_CH];
        void'($urandom(32'd4711));
        @(negedge clk);
        do_reset();

        // R5: a low phase of exactly MIN_LOW is accepted
        err_tag = "R5";
        drive('0, '0, 3);
        drive('0, '1, 2);
        drive('0, '0, MIN_LOW);
        drive('0, '1, 2);
        chk("R5", "div_err after 4-cycle low", div_err[0], 1'b0);

        // R6: a low phase of MIN_LOW-1 sets a sticky flag
        err_tag = "R6";
        drive('0, '0, MIN_LOW - 1);
        drive('0, '1, 1);
        chk("R6", "div_err after 3-cycle low", div_err[1], 1'b1);
        drive('1, '0, 5);
        chk("R6", "div_err sticky after release", div_err[0], 1'b1);

        // R7: first low stretch and deselected activity not measured
        do_reset();
        err_tag = "R7";
        for (int k = 0; k < 4; k++) begin
            drive('1, '1, 1);
            drive('1, '0, 1);
        end
        drive('0, '0, 1);
        drive('0, '1, 2);
        chk("R7", "div_err unmeasured phases", div_err[0], 1'b0);

        // R8: release coinciding with the ending rise
        do_reset();
        err_tag = "R8";
        drive('0, '1, 2);
        drive('0, '0, 2);
        drive('1, '1, 1);
        drive('1, '0, 2);
        chk("R8", "div_err release wins", div_err[1], 1'b0);

        // R9: lanes independent
        do_reset();
        err_tag = "R9";
        drive('0, '1, 2);
        drive('0, '0, 2);
        drive('0, 2'b01, 3);
        drive('0, '1, 2);
        chk("R9", "lane0 flagged", div_err[0], 1'b1);
        chk("R9", "lane1 clean", div_err[1], 1'b0);

        // random bursts
        do_reset();
        err_tag = "R6";
        for (int c = 0; c < NUM_CH; c++) rem[c] = 1;
        for (int cyc = 0; cyc < 3000; cyc++) begin
            if (cyc % 400 == 399) begin
                do_reset();
            end
            for (int c = 0; c < NUM_CH; c++) begin
                rem[c]--;
                if (rem[c] <= 0) begin
                    d_sc[c] = ~d_sc[c];
                    rem[c] = 1 + int'($urandom % 6);
                    if ($urandom % 12 == 0) d_cs[c] = ~d_cs[c];
                end
            end
            d_mo = NUM_CH'($urandom);
            d_mi = NUM_CH'($urandom);
            step();
        end

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule